// File: doc/BRIEF.md
# Serial Loopback Path Selector

This block sits between the parallel word interfaces and the serial line of a 16-bit serial transceiver. It turns outgoing 16-bit words into a bit stream, most significant bit first, and turns an incoming bit stream back into 16-bit words. It also chooses which stream drives the serial output and which stream feeds the receive deserializer.

Four static controls steer the paths:
- **Diagnostic loop** sends the transmit stream back into the receiver.
- **Line loop** sends the recovered, retimed receive bit back out on the line.
- **Raw line loop** sends the un-retimed receive bit back out on the line.
- **Loop timing** makes the transmitter take its bit timing from the recovered receive strobe instead of the reference strobe.

Everything runs on one system clock. Bit timing is carried by single-cycle enable strobes rather than by separate clocks.

When the block is in use, the transmit side loads a new word on the first bit enable after the last bit of the previous word, and marks each load with a one-cycle strobe. The receive side delivers a word with a one-cycle valid pulse after every 16 accepted bits. Word alignment is fixed from reset, and there is no framing search.

Top module: `serloop_path_sel`

## Requirements
- R1: With `diag_loop` high, the receive deserializer takes the transmit serial stream, timed by the transmit bit strobe. Each transmitted word appears unchanged on `rx_word`, and `rx_bit_en`/`rx_rec_bit` activity is ignored.
- R2: With `diag_loop` low, the receive deserializer takes `rx_rec_bit`, sampled on each cycle where `rx_bit_en` is high. The first bit sampled after reset, or after the previous word, becomes `rx_word[15]`.
- R3: With `line_loop` high, `ser_out` carries the value of `rx_rec_bit` captured at the most recent `rx_bit_en`, whatever the other loop controls are.
- R4: With `line_loop` low and `raw_loop` high, `ser_out` follows `rx_raw_bit` in the same cycle, with no retiming.
- R5: With both `line_loop` and `raw_loop` low, `ser_out` is the transmit shifter output: bit 15 of the loaded word first, then bits 14 down to 0, one per transmit bit enable.
- R6: The transmit bit enable is `rx_bit_en` when `loop_time` is high, and `ref_bit_en` when it is low. The strobe that is not selected has no effect on the transmitter.
- R7: The first transmit bit enable after reset loads `tx_word`, and so does every 16th enable after that. `tx_load` is high for exactly the one cycle after each load.
- R8: `rx_valid` is high for exactly one cycle after every 16th accepted receive bit, with the completed word on `rx_word`. No pulse occurs before the 16th bit.
- R9: The four loop controls are registered. A change applied before a clock edge reaches `ser_out` only after that edge.
- R10: While `rst_n` is low at a clock edge, `ser_out`, `tx_load`, `rx_valid` and `rx_word` are all 0 after that edge, whatever the data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_bit_en | input | 1 | Bit strobe derived from the reference clock |
| rx_bit_en | input | 1 | Bit strobe from receive clock recovery |
| rx_raw_bit | input | 1 | Received line bit before retiming |
| rx_rec_bit | input | 1 | Received bit from clock recovery |
| diag_loop | input | 1 | Route transmit stream into the receiver |
| line_loop | input | 1 | Retimed receive bit drives the line output |
| raw_loop | input | 1 | Raw receive bit drives the line output |
| loop_time | input | 1 | Transmit timing follows the recovered strobe |
| tx_word | input | 16 | Word to transmit; must be valid by the next load |
| tx_load | output | 1 | One-cycle pulse: `tx_word` was just loaded |
| ser_out | output | 1 | Serial line output |
| rx_word | output | 16 | Last completed receive word |
| rx_valid | output | 1 | One-cycle pulse: `rx_word` is new |

## Verification
The assertions assume that each bit strobe is a single-cycle pulse. They also assume that the loop controls change only under reset or between words, so that a change of the selected strobe source never splits a word. The stimulus therefore sets the controls before releasing reset, and spaces every strobe with an idle cycle. It changes `tx_word` only in the cycle after `tx_load`, so the value is settled well before the next load 16 enables later.

// File: rtl/serloop_pkg.sv
// Shared types for the serial loopback path selector.
// Assumes: nothing beyond a single synchronous clock domain.
package serloop_pkg;

    // Registered loop control set; one bit per control input.
    typedef struct packed {
        logic diag;    // transmit stream feeds receiver
        logic line;    // retimed receive bit drives line
        logic raw;     // raw receive bit drives line
        logic ltime;   // transmit timing from recovered strobe
    } loop_ctrl_t;

endpackage

// File: rtl/serloop_ctrl_reg.sv
// Registers the static loop controls so mode changes land on a clock edge.
// Assumes: controls are quasi-static and change between words only.
module serloop_ctrl_reg
    import serloop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  loop_ctrl_t ctrl_d,
    output loop_ctrl_t ctrl_q
);

    // Capture the control set every cycle; clear under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/serloop_tx_shifter.sv
// Parallel-to-serial shifter, MSB first, one bit per bit enable.
// Loads a new word on the enable after the last bit of the previous one
// (the first enable after reset also loads) and pulses char_load once.
// Assumes: word_in is stable when bit_en arrives with the count at its end.
module serloop_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              ser_bit,
    output logic              char_load
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    // Shift one bit per enable; reload after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            cnt_q     <= LAST;
            char_load <= 1'b0;
        end else begin
            char_load <= 1'b0;
            if (bit_en) begin
                if (cnt_q == LAST) begin
                    sh_q      <= word_in;
                    cnt_q     <= '0;
                    char_load <= 1'b1;
                end else begin
                    sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign ser_bit = sh_q[WORD_W-1];

    AST_LOAD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        char_load |-> $past(bit_en)); // R7
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        char_load |=> !char_load); // R7
    AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_bit)); // R5

endmodule

// File: rtl/serloop_rx_shifter.sv
// Serial-to-parallel shifter; first accepted bit lands in the MSB.
// Presents a word and a one-cycle valid every WORD_W accepted bits.
// Assumes: fixed alignment from reset; no framing search.
module serloop_rx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] sh_nxt;
    logic [CNT_W-1:0]  cnt_q;

    // Next shift contents with the incoming bit appended.
    always_comb sh_nxt = {sh_q[WORD_W-2:0], bit_in};

    // Accept bits, and publish a word after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (sample_en) begin
                sh_q <= sh_nxt;
                if (cnt_q == LAST) begin
                    cnt_q      <= '0;
                    word_out   <= sh_nxt;
                    word_valid <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R8
    AST_VALID_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(sample_en)); // R8

endmodule

// File: rtl/serloop_path_sel.sv
// Serial loopback path selector: picks the line output source, the
// receive deserializer source and the transmit bit strobe.
// Assumes: strobes are single-cycle pulses in the clk domain; loop
// controls change only under reset or between words.
module serloop_path_sel
    import serloop_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_bit_en,
    input  logic              rx_bit_en,
    input  logic              rx_raw_bit,
    input  logic              rx_rec_bit,
    input  logic              diag_loop,
    input  logic              line_loop,
    input  logic              raw_loop,
    input  logic              loop_time,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_load,
    output logic              ser_out,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    loop_ctrl_t ctrl_d;
    loop_ctrl_t ctrl_q;
    logic       rec_q;        // retimed receive bit
    logic       tx_bit_en;
    logic       tx_ser;
    logic       rx_en_d;      // receive strobe, one cycle late
    logic       rx_bit;

    // Pack the control pins into one set.
    always_comb ctrl_d = '{diag: diag_loop, line: line_loop,
                           raw: raw_loop, ltime: loop_time};

    serloop_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_d (ctrl_d),
        .ctrl_q (ctrl_q)
    );

    // Retime the recovered bit on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= 1'b0;
        end else if (rx_bit_en) begin
            rec_q <= rx_rec_bit;
        end
    end

    // Transmit timing source: recovered or reference strobe.
    always_comb tx_bit_en = ctrl_q.ltime ? rx_bit_en : ref_bit_en;

    serloop_tx_shifter #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (tx_bit_en),
        .word_in   (tx_word),
        .ser_bit   (tx_ser),
        .char_load (tx_load)
    );

    // Delay the chosen receive strobe so the bit it marks has settled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_d <= 1'b0;
        end else begin
            rx_en_d <= ctrl_q.diag ? tx_bit_en : rx_bit_en;
        end
    end

    // Receive source: transmit stream in diagnostic loop, else line.
    always_comb rx_bit = ctrl_q.diag ? tx_ser : rec_q;

    serloop_rx_shifter #(.WORD_W(WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (rx_en_d),
        .bit_in     (rx_bit),
        .word_out   (rx_word),
        .word_valid (rx_valid)
    );

    // Line output priority: retimed loop, raw loop, transmit shifter.
    always_comb begin
        if (ctrl_q.line)     ser_out = rec_q;
        else if (ctrl_q.raw) ser_out = rx_raw_bit;
        else                 ser_out = tx_ser;
    end

    AST_LINE_FOLLOWS_REC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_bit_en) && $past(ctrl_q.line) && ctrl_q.line)
            |-> ser_out == $past(rx_rec_bit)); // R3
    AST_TX_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> ($past(ctrl_q.ltime) ? $past(rx_bit_en)
                                         : $past(ref_bit_en))); // R6

endmodule

// File: tb/serloop_path_sel_test.sv
module serloop_path_sel_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_bit_en = 1'b0, rx_bit_en = 1'b0;
    logic         rx_raw_bit = 1'b0, rx_rec_bit = 1'b0;
    logic         diag_loop = 1'b0, line_loop = 1'b0;
    logic         raw_loop = 1'b0, loop_time = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_load, ser_out, rx_valid;
    logic [W-1:0] rx_word;

    int checks = 0;
    int fails = 0;
    int rx_n = 0;
    int tx_n = 0;
    logic [W-1:0] rx_log [4];
    bit done = 1'b0;

    // Vector: {diag, line, raw, ltime, raw_bit, rec_bit, expected ser_out}
    localparam logic [6:0] VEC [10] = '{
        7'b0_1_0_0_0_1_1,  // R3 retimed bit
        7'b0_1_1_0_0_1_1,  // R3 beats raw loop
        7'b0_1_1_0_1_0_0,  // R3 raw bit ignored
        7'b0_0_1_0_1_0_1,  // R4 raw bit passes
        7'b0_0_1_0_0_1_0,  // R4 retimed bit ignored
        7'b0_0_0_0_1_1_0,  // R5 transmit shifter (zero word)
        7'b0_0_0_1_1_1_0,  // R5 with loop timing
        7'b1_1_0_0_0_1_1,  // R3 diag does not affect line
        7'b1_0_1_0_1_0_1,  // R4 with diag
        7'b1_0_0_0_1_1_0   // R5 with diag
    };

    serloop_path_sel #(.WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ref_bit_en(ref_bit_en), .rx_bit_en(rx_bit_en),
        .rx_raw_bit(rx_raw_bit), .rx_rec_bit(rx_rec_bit), .diag_loop(diag_loop),
        .line_loop(line_loop), .raw_loop(raw_loop), .loop_time(loop_time),
        .tx_word(tx_word), .tx_load(tx_load), .ser_out(ser_out),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Record output pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (rx_n < 4) rx_log[rx_n] = rx_word;
                rx_n = rx_n + 1;
            end
            if (tx_load) tx_n = tx_n + 1;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_bit_en = 1'b0;
        rx_bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rx_n = 0;
        tx_n = 0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One-cycle strobe on either source, then an idle cycle boundary.
    task automatic strobe(input logic r, input logic c);
        @(negedge clk);
        ref_bit_en = r;
        rx_bit_en = c;
        @(negedge clk);
        ref_bit_en = 1'b0;
        rx_bit_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got %h expected %h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;

        // R10: outputs cleared under reset despite active data inputs
        line_loop = 1'b1; raw_loop = 1'b1; rx_rec_bit = 1'b1; rx_raw_bit = 1'b1;
        rx_bit_en = 1'b1;
        repeat (3) @(negedge clk);
        check(ser_out == 1'b0 && tx_load == 1'b0 && rx_valid == 1'b0 && rx_word == '0,
              "R10 reset", {tx_load, ser_out, rx_valid, rx_word}, 0);
        rx_bit_en = 1'b0;

        // Mux table: R3 R4 R5 priority over all control combinations
        line_loop = 1'b0; raw_loop = 1'b0;
        tx_word = '0;
        do_reset();
        for (int i = 0; i < 10; i++) begin
            logic [6:0] v;
            v = VEC[i];
            diag_loop = v[6]; line_loop = v[5]; raw_loop = v[4]; loop_time = v[3];
            rx_raw_bit = v[2]; rx_rec_bit = v[1];
            strobe(1'b0, 1'b1);
            repeat (2) @(negedge clk);
            check(ser_out == v[0], "R3/R4/R5 table", ser_out, v[0]);
        end

        // R9: control change reaches ser_out only after the next edge
        diag_loop = 1'b0; line_loop = 1'b0; raw_loop = 1'b0; loop_time = 1'b0;
        do_reset();
        rx_rec_bit = 1'b1;
        strobe(1'b0, 1'b1);
        @(negedge clk);
        line_loop = 1'b1;
        #1;
        check(ser_out == 1'b0, "R9 before edge", ser_out, 0);
        @(negedge clk);
        check(ser_out == 1'b1, "R9 after edge", ser_out, 1);

        // R5/R7: transmit shifter MSB first and reload timing
        line_loop = 1'b0;
        tx_word = 16'hB2D9;
        do_reset();
        got = '0;
        for (int k = 0; k < W; k++) begin
            strobe(1'b1, 1'b0);
            got = {got[W-2:0], ser_out};
            if (k == 0) tx_word = 16'h8001;
        end
        #1;
        check(got == 16'hB2D9, "R5 MSB-first order", got, 16'hB2D9);
        check(tx_n == 1, "R7 one load per word", tx_n, 1);
        strobe(1'b1, 1'b0);
        #1;
        check(tx_n == 2 && ser_out == 1'b1, "R7 reload on 17th enable",
              {tx_n[7:0], 7'b0, ser_out}, {8'd2, 8'd1});

        // R2/R8: line receive from retimed bit; raw bit carries opposite data
        tx_word = 16'hFFFF;
        do_reset();
        for (int k = W - 1; k >= 0; k--) begin
            rx_rec_bit = got[k] ^ 1'b1;
            rx_raw_bit = got[k];
            strobe(1'b0, 1'b1);
            if (k == 1) begin
                @(negedge clk);
                #1;
                check(rx_n == 0, "R8 no early valid", rx_n, 0);
            end
        end
        @(negedge clk);
        #1;
        check(rx_n == 1, "R8 single valid pulse", rx_n, 1);
        check(rx_log[0] == ~16'hB2D9, "R2 line word", rx_log[0], ~16'hB2D9);
        check(tx_n == 0, "R6 recovered strobe ignored when loop_time low", tx_n, 0);

        // R1: diagnostic loop carries two words; line activity ignored
        diag_loop = 1'b1;
        tx_word = 16'h3C5A;
        do_reset();
        for (int k = 0; k < 2 * W; k++) begin
            strobe(1'b1, 1'b0);
            if (k == 0) tx_word = 16'hE71B;
            rx_rec_bit = k[0];
            strobe(1'b0, 1'b1);
        end
        @(negedge clk);
        #1;
        check(rx_n == 2, "R1 word count", rx_n, 2);
        check(rx_log[0] == 16'h3C5A, "R1 first word", rx_log[0], 16'h3C5A);
        check(rx_log[1] == 16'hE71B, "R1 second word", rx_log[1], 16'hE71B);

        // R6: loop timing uses the recovered strobe only
        loop_time = 1'b1;
        tx_word = 16'h0F96;
        do_reset();
        for (int k = 0; k < 5; k++) strobe(1'b1, 1'b0);
        #1;
        check(tx_n == 0, "R6 reference strobe ignored", tx_n, 0);
        for (int k = 0; k < W; k++) strobe(1'b0, 1'b1);
        @(negedge clk);
        #1;
        check(tx_n == 1, "R6 load on recovered strobe", tx_n, 1);
        check(rx_n == 1 && rx_log[0] == 16'h0F96, "R6 looped word", rx_log[0], 16'h0F96);

        // R10: reset after activity clears the word output
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(rx_word == '0 && rx_valid == 1'b0 && tx_load == 1'b0,
              "R10 reset after traffic", rx_word, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule